// File: doc/BRIEF.md
# Codec Indexed Register Interface

This block is the host-facing control interface of an audio codec. The host sees four byte-wide ports, selected by a two-bit address:

| Address | Port |
|---|---|
| 0 | index |
| 1 | data |
| 2 | status |
| 3 | polled I/O |

A write to the index port picks one of the indirect 8-bit registers and sets a mode-change-enable (MCE) flag. The data port then reads or writes the picked register. In the default mode there are 16 physical registers, and indices 16 to 31 fold onto them. Setting the extended-mode bit makes all 32 indices distinct.

The block reports when it is not ready. After reset it runs an initialisation interval, and after every accepted write to the format register it runs a resynchronisation interval. During either interval the index port reads as the busy code 0x80 and host writes to the index and data ports are dropped. When MCE is cleared while auto-calibration is enabled, a calibration flag in register 11 rises for a fixed window and then falls. An interrupt-pending flag is set by the audio datapath and cleared by any host write to the status port.

The format, interface-configuration and 16-bit count registers are driven continuously to neighbouring blocks. There is no streaming data path, so no valid/ready handshake is needed. Reads are combinational from the address, and writes take effect on the clock edge where `host_wr` is high.

Top module: `codec_regif`

## Requirements
- R1: After reset, the index port reads exactly 0x80 for INIT_CYC cycles. When idle it reads {0, MCE, 0, index[4:0]}, so bit 7 is 0; the value after initialisation is 0x00.
- R2: An accepted index-port write takes MCE from data bit 6 and the index from bits 4:0. Index- and data-port writes made while busy are ignored.
- R3: Reset defaults: registers 0–5 hold 0x08, register 9 holds 0x08, register 10 holds 0x02, and all others hold 0x00.
- R4: Bit 4 of registers 0 and 1 is read-only and reads 0.
- R5: Register 12 reads {1, XMODE, 00, REV}, with REV defaulting to 0xA. Only bit 6 (XMODE) is writable.
- R6: With XMODE at 0, indices 16–31 address the same storage as indices 0–15.
- R7: With XMODE at 1, indices 16–31 are separate registers, so a write to register 0 leaves register 16 unchanged.
- R8: Writes to registers 8 and 9 take effect only while MCE is 1. An accepted write to register 8 makes the index port read 0x80 for RESYNC_CYC cycles.
- R9: Register 11 bit 5 reads 1 for CAL_CYC cycles after an index write takes MCE from 1 to 0 while register 9 bit 3 is set. Otherwise it stays 0. The other bits of register 11 read 0, and writes to it are ignored.
- R10: `fmt_cfg` shows register 8, `iface_cfg` shows register 9, and `xfer_count` shows {register 14, register 15}.
- R11: `irq_event` sets the pending flag. Any status-port write clears it, but a set in the same cycle wins. A status-port read returns {0000000, pending}.
- R12: The polled I/O port reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Port select (0 index, 1 data, 2 status, 3 polled I/O) |
| host_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the port selected by host_addr |
| irq_event | input | 1 | One-cycle interrupt request from the audio datapath |
| irq_pending | output | 1 | Interrupt-pending flag |
| fmt_cfg | output | 8 | Contents of register 8 |
| iface_cfg | output | 8 | Contents of register 9 |
| xfer_count | output | 16 | {register 14, register 15} |

## Verification
The status-port clear and an incoming `irq_event` can land on the same clock edge. The bench drives a status-port write with `irq_event` held high in the same cycle and expects the status read afterwards to still show a pending interrupt. A second collision is a host index or data write that arrives inside the resynchronisation window. That write must leave both the index and the register contents exactly as they were once the window has closed.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;

  localparam logic [1:0] PORT_INDEX  = 2'd0;
  localparam logic [1:0] PORT_DATA   = 2'd1;
  localparam logic [1:0] PORT_STATUS = 2'd2;
  localparam logic [1:0] PORT_POLL   = 2'd3;

  localparam int NUM_REGS = 32;
  localparam int AW       = $clog2(NUM_REGS);

  localparam logic [AW-1:0] REG_FMT    = AW'(8);
  localparam logic [AW-1:0] REG_IFC    = AW'(9);
  localparam logic [AW-1:0] REG_CALST  = AW'(11);
  localparam logic [AW-1:0] REG_ID     = AW'(12);
  localparam logic [AW-1:0] REG_CNT_HI = AW'(14);
  localparam logic [AW-1:0] REG_CNT_LO = AW'(15);

  localparam int IFC_AUTOCAL_BIT = 3;
  localparam int ID_XMODE_BIT    = 6;
  localparam logic [7:0] BUSY_CODE = 8'h80;

  function automatic logic [7:0] reg_default(int unsigned a);
    if (a <= 5)       return 8'h08;
    else if (a == 9)  return 8'h08;
    else if (a == 10) return 8'h02;
    else              return 8'h00;
  endfunction

  // Bits that host writes cannot change.
  function automatic logic [7:0] ro_mask(int unsigned a);
    if (a == 0 || a == 1) return 8'h10;
    else if (a == 11)     return 8'hFF;
    else if (a == 12)     return 8'hBF;
    else                  return 8'h00;
  endfunction

endpackage

// File: rtl/regif_interval.sv
module regif_interval #(
  parameter int W       = 9,
  parameter int RST_LEN = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         active
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= W'(RST_LEN);
    else if (load)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  AST_INTERVAL_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load) |=> (cnt == $past(cnt) - 1'b1)); // R8

endmodule

// File: rtl/regif_regfile.sv
module regif_regfile
  import codec_regif_pkg::*;
#(
  parameter logic [3:0] REV = 4'hA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] idx,
  input  logic          mce,
  input  logic          we,
  input  logic [7:0]    wdata,
  input  logic          cal_busy,
  output logic [7:0]    rdata,
  output logic          fmt_wr,
  output logic [7:0]    fmt,
  output logic [7:0]    ifc,
  output logic [15:0]   cnt16
);

  logic [7:0]    mem [NUM_REGS];
  logic          xmode;
  logic [AW-1:0] pa;
  logic          gated;
  logic          we_eff;

  assign xmode  = mem[REG_ID][ID_XMODE_BIT];
  assign pa     = xmode ? idx : {1'b0, idx[AW-2:0]};
  assign gated  = (pa == REG_FMT) || (pa == REG_IFC);
  assign we_eff = we && (mce || !gated);
  assign fmt_wr = we_eff && (pa == REG_FMT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= reg_default(i);
    end else if (we_eff) begin
      mem[pa] <= (wdata & ~ro_mask(pa)) | (mem[pa] & ro_mask(pa));
    end
  end

  always_comb begin
    unique case (pa)
      REG_CALST: rdata = {2'b00, cal_busy, 5'b00000};
      REG_ID:    rdata = {1'b1, xmode, 2'b00, REV};
      default:   rdata = mem[pa];
    endcase
  end

  assign fmt   = mem[REG_FMT];
  assign ifc   = mem[REG_IFC];
  assign cnt16 = {mem[REG_CNT_HI], mem[REG_CNT_LO]};

  AST_FMT_GATED_BY_MCE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !mce) |=> $stable(fmt) && $stable(ifc)); // R8

  AST_VOLUME_BIT4_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[0][4] == 1'b0) && (mem[1][4] == 1'b0)); // R4

endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
#(
  parameter int         INIT_CYC   = 64,
  parameter int         RESYNC_CYC = 64,
  parameter int         CAL_CYC    = 384,
  parameter logic [3:0] REV        = 4'hA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  host_addr,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic        irq_event,
  output logic        irq_pending,
  output logic [7:0]  fmt_cfg,
  output logic [7:0]  iface_cfg,
  output logic [15:0] xfer_count
);

  localparam int MAX_BUSY = (INIT_CYC > RESYNC_CYC) ? INIT_CYC : RESYNC_CYC;
  localparam int BW       = $clog2(MAX_BUSY + 1);
  localparam int CW       = $clog2(CAL_CYC + 1);

  logic          busy, cal_active;
  logic          mce_q;
  logic [AW-1:0] idx_q;
  logic          idx_wr, data_wr, stat_wr;
  logic          cal_start, fmt_wr;
  logic [7:0]    reg_rdata;

  assign idx_wr  = host_wr && (host_addr == PORT_INDEX) && !busy;
  assign data_wr = host_wr && (host_addr == PORT_DATA)  && !busy;
  assign stat_wr = host_wr && (host_addr == PORT_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mce_q <= 1'b0;
      idx_q <= '0;
    end else if (idx_wr) begin
      mce_q <= host_wdata[6];
      idx_q <= host_wdata[AW-1:0];
    end
  end

  assign cal_start = idx_wr && mce_q && !host_wdata[6] && iface_cfg[IFC_AUTOCAL_BIT];

  regif_interval #(.W(BW), .RST_LEN(INIT_CYC)) u_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (fmt_wr),
    .len    (BW'(RESYNC_CYC)),
    .active (busy)
  );

  regif_interval #(.W(CW), .RST_LEN(0)) u_cal (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cal_start),
    .len    (CW'(CAL_CYC)),
    .active (cal_active)
  );

  regif_regfile #(.REV(REV)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (idx_q),
    .mce      (mce_q),
    .we       (data_wr),
    .wdata    (host_wdata),
    .cal_busy (cal_active),
    .rdata    (reg_rdata),
    .fmt_wr   (fmt_wr),
    .fmt      (fmt_cfg),
    .ifc      (iface_cfg),
    .cnt16    (xfer_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_pending <= 1'b0;
    else if (irq_event) irq_pending <= 1'b1;
    else if (stat_wr)   irq_pending <= 1'b0;
  end

  always_comb begin
    unique case (host_addr)
      PORT_INDEX:  host_rdata = busy ? BUSY_CODE : {1'b0, mce_q, 1'b0, idx_q};
      PORT_DATA:   host_rdata = reg_rdata;
      PORT_STATUS: host_rdata = {7'b0, irq_pending};
      default:     host_rdata = 8'h00;
    endcase
  end

  AST_INDEX_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr && host_addr == PORT_INDEX) |=> $stable(idx_q) && $stable(mce_q)); // R2

  AST_RESYNC_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_wr |=> busy); // R8

  AST_CAL_FLAG_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> cal_active); // R9

  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |=> irq_pending); // R11

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !irq_event) |=> !irq_pending); // R11

endmodule

// File: tb/test_codec_regif.sv
module test_codec_regif;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        irq_event = 1'b0;
  logic        irq_pending;
  logic [7:0]  fmt_cfg, iface_cfg;
  logic [15:0] xfer_count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  codec_regif i_codec_regif (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_event(irq_event),
    .irq_pending(irq_pending), .fmt_cfg(fmt_cfg), .iface_cfg(iface_cfg),
    .xfer_count(xfer_count)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #2 d = host_rdata;
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
    wr(2'd0, ix);
    wr(2'd1, d);
  endtask

  task automatic reg_rd(input logic [7:0] ix, output logic [7:0] d);
    wr(2'd0, ix);
    rd(2'd1, d);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d);       chk("R1 busy during init", d, 8'h80);
    wait_cyc(70);
    rd(2'd0, d);       chk("R1 idle index", d, 8'h00);
    reg_rd(8'h00, d);  chk("R3 reg0 default", d, 8'h08);
    reg_rd(8'h0A, d);  chk("R3 reg10 default", d, 8'h02);
    chk("R3 reg9 default", iface_cfg, 8'h08);
    chk("R10 fmt default", fmt_cfg, 8'h00);
  endtask

  task automatic t_readonly;
    logic [7:0] d;
    reg_wr(8'h00, 8'hFF); reg_rd(8'h00, d); chk("R4 reg0 bit4", d, 8'hEF);
    reg_wr(8'h01, 8'h55); reg_rd(8'h01, d); chk("R4 reg1 bit4", d, 8'h45);
    reg_wr(8'h0C, 8'h0F); reg_rd(8'h0C, d); chk("R5 id reg", d, 8'h8A);
    reg_wr(8'h0B, 8'hFF); reg_rd(8'h0B, d); chk("R9 reg11 read-only", d, 8'h00);
    rd(2'd0, d);                            chk("R2 index readback", d, 8'h0B);
  endtask

  task automatic t_alias;
    logic [7:0] d;
    reg_wr(8'h10, 8'h2A); reg_rd(8'h00, d); chk("R6 alias 16->0", d, 8'h2A);
    reg_rd(8'h11, d);                       chk("R6 alias 17->1", d, 8'h45);
    reg_wr(8'h0C, 8'h40); reg_rd(8'h0C, d); chk("R5 xmode set", d, 8'hCA);
    reg_wr(8'h10, 8'h00); reg_wr(8'h00, 8'h45);
    reg_rd(8'h10, d);                       chk("R7 reg16 separate", d, 8'h00);
    reg_rd(8'h00, d);                       chk("R7 reg0 value", d, 8'h45);
    reg_wr(8'h0C, 8'h00);
  endtask

  task automatic t_resync;
    logic [7:0] d;
    reg_wr(8'h08, 8'h5B);                   chk("R8 fmt gated by mce", fmt_cfg, 8'h00);
    reg_wr(8'h48, 8'h5B);                   chk("R10 fmt output", fmt_cfg, 8'h5B);
    rd(2'd0, d);                            chk("R8 busy after fmt write", d, 8'h80);
    wr(2'd0, 8'h0E); wr(2'd1, 8'h99);
    wait_cyc(52);
    rd(2'd0, d);                            chk("R8 still busy", d, 8'h80);
    wait_cyc(12);
    rd(2'd0, d);                            chk("R2 index unchanged by busy write", d, 8'h48);
    reg_rd(8'h4E, d);                       chk("R2 data write ignored while busy", d, 8'h00);
  endtask

  task automatic t_calib;
    logic [7:0] d;
    wr(2'd0, 8'h0B);
    rd(2'd1, d);                            chk("R9 flag rises", d, 8'h20);
    wait_cyc(370);
    rd(2'd1, d);                            chk("R9 flag still high", d, 8'h20);
    wait_cyc(20);
    rd(2'd1, d);                            chk("R9 flag falls", d, 8'h00);
    reg_wr(8'h49, 8'h00);                   chk("R10 iface output", iface_cfg, 8'h00);
    wr(2'd0, 8'h0B);
    rd(2'd1, d);                            chk("R9 no cal when disabled", d, 8'h00);
  endtask

  task automatic t_count_irq;
    logic [7:0] d;
    reg_wr(8'h0E, 8'h12); reg_wr(8'h0F, 8'h34);
    chk("R10 count output", xfer_count, 16'h1234);
    rd(2'd2, d);                            chk("R11 idle status", d, 8'h00);
    @(negedge clk); irq_event = 1'b1; @(negedge clk); irq_event = 1'b0;
    rd(2'd2, d);                            chk("R11 pending set", d, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd2, d);                            chk("R11 cleared by write", d, 8'h00);
    @(negedge clk);
    host_addr = 2'd2; host_wr = 1'b1; irq_event = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; irq_event = 1'b0;
    rd(2'd2, d);                            chk("R11 set wins collision", d, 8'h01);
    wr(2'd3, 8'hFF);
    rd(2'd3, d);                            chk("R12 polled port", d, 8'h00);
    chk("R12 write no effect", {fmt_cfg, xfer_count[7:0]}, 16'h5B34);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readonly();
    t_alias();
    t_resync();
    t_calib();
    t_count_irq();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule